// File: doc/BRIEF.md
# Programmable-Frame Serial Transmitter

This block turns bytes written into it into asynchronous serial frames on a single line. A byte enters through a one-cycle write strobe and waits in a transmit buffer. The buffer is a queue of `DEPTH` entries when queue mode is selected, and a single holding register otherwise. The frame has a low start bit and then 5 to 8 data bits, least significant first. An optional parity bit follows, which can be odd, even or forced to a constant. The frame ends with one or two high stop bits.

Bit timing comes from an external `baud_tick` strobe. Every serial bit lasts exactly from one tick to the next. Frames for queued bytes follow each other with no idle gap. A break request holds the line low, but only after the character on the wire has finished. The busy, empty and full flags let the surrounding logic pace its writes.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the line `txd` is high, `tx_busy` is 0, `tx_empty` is 1 and `tx_full` is 0. The line is high whenever no character and no break is being sent.
- R2: A frame starts with one low bit, followed by N data bits least significant first. `cfg_word_len` sets N: 2'b00 gives 5, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Only the low N bits of the byte are sent.
- R3: With `cfg_par_en`=1 and `cfg_stick`=0, one parity bit follows the data bits. With `cfg_even`=1 it makes the count of ones over the sent data and parity bits even. With `cfg_even`=0 it makes that count odd. With `cfg_par_en`=0 no parity bit is sent.
- R4: With `cfg_par_en`=1 and `cfg_stick`=1, the parity bit is the constant NOT `cfg_even`: 1 when `cfg_even`=0 and 0 when `cfg_even`=1.
- R5: The frame ends with one high stop bit, or with two when `cfg_two_stop`=1.
- R6: While `cfg_break`=1 the line is held low. A break never cuts a character short; it begins at the first bit boundary after the current frame ends. It takes priority over starting queued bytes. After `cfg_break` clears, the line returns high at the next bit boundary.
- R7: Clearing `cfg_enable` during a character lets that character finish. No new character starts while `cfg_enable`=0.
- R8: With `cfg_fifo_mode`=0 the buffer holds one byte. `tx_full` is 1 and `tx_empty` is 0 while that byte waits. `tx_full` and `tx_empty` are never both 1.
- R9: With `cfg_fifo_mode`=1 the buffer holds `DEPTH` bytes. `tx_full` rises only when the `DEPTH`-th byte is written, and the bytes go out in write order.
- R10: A write made while `tx_full`=1 is dropped and changes nothing.
- R11: `tx_busy` rises in the cycle after a write makes the buffer non-empty, even when `cfg_enable`=0. It stays high until the final stop bit of the last character has ended.
- R12: `tx_empty` reflects only the buffer. It is 1 while the last byte is still being shifted out.
- R13: Each bit lasts one `baud_tick` period. A queued byte's start bit directly follows the previous frame's last stop bit. The frame format is sampled when a character starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | One pulse per serial bit period |
| cfg_enable | input | 1 | Allows new characters to start |
| cfg_fifo_mode | input | 1 | 1: queue of DEPTH entries, 0: one holding register |
| cfg_word_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Constant parity bit select |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_break | input | 1 | Hold line low after current character |
| txd | output | 1 | Serial output, idles high |
| tx_busy | output | 1 | Buffer non-empty or character on the wire |
| tx_empty | output | 1 | Buffer empty |
| tx_full | output | 1 | Buffer full |

## Verification
The hardest cases are the ones where a control input changes while a character is on the wire. These are a break request or an enable drop landing mid-frame, with more bytes waiting behind it. The bench disables the block, queues two bytes and enables it. It then watches for the start bit at the falling clock edge and changes the control in that same cycle. This places the change at a known bit of the first frame. The rest of that frame is then checked bit for bit, followed by the held line and the late start of the second byte. The frame format is swept over every word length, parity mode and stop count, at two tick rates.

// File: rtl/uft_pkg.sv
package uft_pkg;

    localparam int CHAR_W   = 8;
    localparam int BITCNT_W = $clog2(CHAR_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2,
        ST_BREAK
    } tx_state_e;

    typedef struct packed {
        logic [1:0] word_len;
        logic       par_en;
        logic       even;
        logic       stick;
        logic       two_stop;
    } frame_cfg_t;

    function automatic logic [BITCNT_W-1:0] data_bits(input logic [1:0] wl);
        return BITCNT_W'(5) + BITCNT_W'(wl);
    endfunction

    function automatic logic parity_of(input logic [CHAR_W-1:0] d, input frame_cfg_t c);
        logic [CHAR_W-1:0] mask;
        logic              ones_odd;
        mask     = {CHAR_W{1'b1}} >> (2'd3 - c.word_len);
        ones_odd = ^(d & mask);
        if (c.stick) return ~c.even;
        return c.even ? ones_odd : ~ones_odd;
    endfunction

endpackage

// File: rtl/uft_txbuf.sv
module uft_txbuf #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_mode,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head_data,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        rd_ptr;
        logic [PTR_W-1:0]        wr_ptr;
        logic [CNT_W-1:0]        count;
    } buf_state_t;

    buf_state_t st_q, st_d;
    logic [CNT_W-1:0] capacity;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        logic [PTR_W-1:0] r;
        if (32'(p) == DEPTH - 1) r = '0;
        else                     r = p + 1'b1;
        return r;
    endfunction

    always_comb begin
        capacity  = fifo_mode ? CNT_W'(DEPTH) : CNT_W'(1);
        empty     = (st_q.count == '0);
        full      = (st_q.count >= capacity);
        head_data = st_q.mem[st_q.rd_ptr];
        do_push   = push && !full;
        do_pop    = pop && !empty;

        st_d = st_q;
        if (do_push) begin
            st_d.mem[st_q.wr_ptr] = push_data;
            st_d.wr_ptr           = ptr_next(st_q.wr_ptr);
        end
        if (do_pop) begin
            st_d.rd_ptr = ptr_next(st_q.rd_ptr);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/uft_serializer.sv
module uft_serializer
    import uft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              enable,
    input  logic              brk,
    input  frame_cfg_t        cfg,
    input  logic              buf_empty,
    input  logic [CHAR_W-1:0] buf_data,
    output logic              pop,
    output logic              txd,
    output logic              in_char
);
    typedef struct packed {
        tx_state_e           state;
        logic [CHAR_W-1:0]   shreg;
        logic [BITCNT_W-1:0] sent;
        frame_cfg_t          fcfg;
        logic                par;
        logic                txd;
    } ser_state_t;

    ser_state_t st_q, st_d;
    logic       decide;

    always_comb begin
        st_d   = st_q;
        pop    = 1'b0;
        decide = 1'b0;

        if (baud_tick) begin
            case (st_q.state)
                ST_IDLE: decide = 1'b1;
                ST_START: begin
                    st_d.state = ST_DATA;
                    st_d.txd   = st_q.shreg[0];
                    st_d.shreg = st_q.shreg >> 1;
                    st_d.sent  = BITCNT_W'(1);
                end
                ST_DATA: begin
                    if (st_q.sent == data_bits(st_q.fcfg.word_len)) begin
                        if (st_q.fcfg.par_en) begin
                            st_d.state = ST_PARITY;
                            st_d.txd   = st_q.par;
                        end else begin
                            st_d.state = ST_STOP1;
                            st_d.txd   = 1'b1;
                        end
                    end else begin
                        st_d.txd   = st_q.shreg[0];
                        st_d.shreg = st_q.shreg >> 1;
                        st_d.sent  = st_q.sent + 1'b1;
                    end
                end
                ST_PARITY: begin
                    st_d.state = ST_STOP1;
                    st_d.txd   = 1'b1;
                end
                ST_STOP1: begin
                    if (st_q.fcfg.two_stop) begin
                        st_d.state = ST_STOP2;
                        st_d.txd   = 1'b1;
                    end else begin
                        decide = 1'b1;
                    end
                end
                ST_STOP2: decide = 1'b1;
                ST_BREAK: begin
                    if (!brk) begin
                        st_d.state = ST_IDLE;
                        st_d.txd   = 1'b1;
                    end
                end
                default: begin
                    st_d.state = ST_IDLE;
                    st_d.txd   = 1'b1;
                end
            endcase
        end

        if (decide) begin
            if (brk) begin
                st_d.state = ST_BREAK;
                st_d.txd   = 1'b0;
            end else if (enable && !buf_empty) begin
                pop        = 1'b1;
                st_d.state = ST_START;
                st_d.txd   = 1'b0;
                st_d.shreg = buf_data;
                st_d.fcfg  = cfg;
                st_d.par   = parity_of(buf_data, cfg);
                st_d.sent  = '0;
            end else begin
                st_d.state = ST_IDLE;
                st_d.txd   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.txd   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd     = st_q.txd;
    assign in_char = (st_q.state != ST_IDLE) && (st_q.state != ST_BREAK);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       baud_tick,
    input  logic       cfg_enable,
    input  logic       cfg_fifo_mode,
    input  logic [1:0] cfg_word_len,
    input  logic       cfg_par_en,
    input  logic       cfg_even,
    input  logic       cfg_stick,
    input  logic       cfg_two_stop,
    input  logic       cfg_break,
    output logic       txd,
    output logic       tx_busy,
    output logic       tx_empty,
    output logic       tx_full
);
    import uft_pkg::*;

    frame_cfg_t        cfg;
    logic [CHAR_W-1:0] head;
    logic              pop, in_char;

    assign cfg = '{word_len: cfg_word_len, par_en: cfg_par_en, even: cfg_even,
                   stick: cfg_stick, two_stop: cfg_two_stop};

    uft_txbuf #(.DEPTH(DEPTH), .W(CHAR_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (cfg_fifo_mode),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head_data (head),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    uft_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .enable    (cfg_enable),
        .brk       (cfg_break),
        .cfg       (cfg),
        .buf_empty (tx_empty),
        .buf_data  (head),
        .pop       (pop),
        .txd       (txd),
        .in_char   (in_char)
    );

    assign tx_busy = !tx_empty || in_char;

endmodule

// File: rtl/uft_checker.sv
module uft_checker (
    input logic clk,
    input logic rst_n,
    input logic baud_tick,
    input logic cfg_fifo_mode,
    input logic cfg_break,
    input logic txd,
    input logic tx_busy,
    input logic tx_empty,
    input logic tx_full
);
    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty));

    assert_busy_nonempty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_empty |-> tx_busy);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && $past(baud_tick) && !$past(cfg_break)) |-> txd);

    assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tx_full) && !$past(baud_tick) && ($past(cfg_fifo_mode) == cfg_fifo_mode))
        |-> tx_full);

    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_break) && $past(baud_tick) && !tx_busy) |-> !txd);

endmodule

bind uart_frame_tx uft_checker chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .baud_tick     (baud_tick),
    .cfg_fifo_mode (cfg_fifo_mode),
    .cfg_break     (cfg_break),
    .txd           (txd),
    .tx_busy       (tx_busy),
    .tx_empty      (tx_empty),
    .tx_full       (tx_full)
);

// File: tb/uart_frame_tx_test.sv
`timescale 1ns/1ps
module uart_frame_tx_test;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick = 1'b0;
    logic       cfg_enable = 1'b0, cfg_fifo_mode = 1'b0;
    logic [1:0] cfg_word_len = 2'b11;
    logic       cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0;
    logic       cfg_two_stop = 1'b0, cfg_break = 1'b0;
    logic       txd, tx_busy, tx_empty, tx_full;

    int vectors = 0;
    int fails   = 0;
    int div     = 1;
    int tcnt    = 0;
    bit done    = 0;

    uart_frame_tx #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .cfg_enable(cfg_enable), .cfg_fifo_mode(cfg_fifo_mode),
        .cfg_word_len(cfg_word_len), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
        .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop), .cfg_break(cfg_break),
        .txd(txd), .tx_busy(tx_busy), .tx_empty(tx_empty), .tx_full(tx_full)
    );

    always #2.5 clk = ~clk;

    // R13: tick generator, one pulse every div cycles
    always @(negedge clk) begin
        if (tcnt >= div - 1) tcnt <= 0;
        else                 tcnt <= tcnt + 1;
        baud_tick <= (tcnt >= div - 1);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start(input string tag);
        int n = 0;
        @(negedge clk);
        while (txd !== 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) check(0, {tag, " start timeout"}, txd, 0);
    endtask

    // positioned on the start-bit sample; checks data, parity and stop bits
    task automatic check_body(input logic [7:0] b, input string tag);
        logic exp_bits [12];
        int   nb, n, bad_i;
        int   ones;
        logic act_bit;
        bad_i = -1;
        act_bit = 1'b0;
        nb = 5 + int'(cfg_word_len);
        n = 0;
        ones = 0;
        for (int i = 0; i < nb; i++) begin
            exp_bits[n] = b[i];
            ones += int'(b[i]);
            n++;
        end
        if (cfg_par_en) begin
            if (cfg_stick)     exp_bits[n] = ~cfg_even;
            else if (cfg_even) exp_bits[n] = logic'(ones % 2);
            else               exp_bits[n] = logic'(1 - ones % 2);
            n++;
        end
        exp_bits[n] = 1'b1; n++;
        if (cfg_two_stop) begin exp_bits[n] = 1'b1; n++; end
        for (int i = 0; i < n; i++) begin
            repeat (div) @(negedge clk);
            if (txd !== exp_bits[i] && bad_i < 0) begin
                bad_i = i;
                act_bit = txd;
            end
        end
        if (bad_i >= 0)
            check(0, $sformatf("%s byte %0h bit %0d", tag, b, bad_i), act_bit, exp_bits[bad_i]);
        else
            check(1, tag, 0, 0);
    endtask

    task automatic expect_frame(input logic [7:0] b, input bit strict, input string tag);
        if (strict) begin
            repeat (div) @(negedge clk);
            check(txd === 1'b0, {tag, " R13 back-to-back start"}, txd, 0);
        end else begin
            wait_start(tag);
        end
        check_body(b, tag);
    endtask

    task automatic tail_idle(input string tag);
        repeat (div) @(negedge clk);
        check(tx_busy === 1'b0 && txd === 1'b1 && tx_empty === 1'b1,
              {tag, " R11 busy falls after last stop"}, {tx_busy, txd, tx_empty}, 3'b011);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [7:0] b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd === 1'b1 && tx_busy === 1'b0 && tx_empty === 1'b1 && tx_full === 1'b0,
              "R1 reset state", {txd, tx_busy, tx_empty, tx_full}, 4'b1010);

        // Format sweep: R2 R3 R4 R5 R13, two tick rates
        for (int d = 1; d <= 3; d += 2) begin
            div = d;
            cfg_fifo_mode = 1'b1;
            for (int wl = 0; wl < 4; wl++)
                for (int pm = 0; pm < 5; pm++)
                    for (int st = 0; st < 2; st++) begin
                        cfg_enable   = 1'b0;
                        cfg_word_len = 2'(wl);
                        cfg_par_en   = (pm != 0);
                        cfg_stick    = (pm >= 3);
                        cfg_even     = (pm == 2) || (pm == 4);
                        cfg_two_stop = st[0];
                        tag = (pm == 0) ? "R2" : (pm < 3) ? "R3" : "R4";
                        if (st) tag = {tag, " R5"};
                        b1 = 8'((wl * 37 + pm * 11 + st * 5 + d * 3 + 8'h5A) & 8'hFF);
                        wr(b1);
                        wr(~b1);
                        @(negedge clk);
                        cfg_enable = 1'b1;
                        expect_frame(b1, 0, tag);
                        expect_frame(~b1, 1, tag);
                        tail_idle(tag);
                    end
        end
        div = 1;
        cfg_word_len = 2'b11; cfg_par_en = 0; cfg_stick = 0; cfg_even = 0; cfg_two_stop = 0;

        // R8 R10 R11 R12: character mode, disabled
        cfg_enable = 1'b0;
        cfg_fifo_mode = 1'b0;
        wr(8'hA5);
        check(tx_full === 1'b1 && tx_empty === 1'b0, "R8 holding register full",
              {tx_full, tx_empty}, 2'b10);
        check(tx_busy === 1'b1, "R11 busy while disabled", tx_busy, 1);
        wr(8'h3C);
        @(negedge clk);
        cfg_enable = 1'b1;
        wait_start("R8");
        check(tx_empty === 1'b1 && tx_busy === 1'b1, "R12 empty while shifting",
              {tx_empty, tx_busy}, 2'b11);
        check_body(8'hA5, "R8");
        tail_idle("R10");
        begin
            bit stayed = 1;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) stayed = 0;
            end
            check(stayed, "R10 dropped write never sent", stayed, 1);
        end

        // R9 R10: FIFO fill to DEPTH
        cfg_enable = 1'b0;
        cfg_fifo_mode = 1'b1;
        for (int i = 0; i < DEPTH - 1; i++) wr(8'(i * 17 + 3));
        check(tx_full === 1'b0, "R9 not full below depth", tx_full, 0);
        wr(8'((DEPTH - 1) * 17 + 3));
        check(tx_full === 1'b1, "R9 full at depth", tx_full, 1);
        wr(8'hEE);
        check(tx_full === 1'b1, "R10 still full after dropped write", tx_full, 1);
        @(negedge clk);
        cfg_enable = 1'b1;
        for (int i = 0; i < DEPTH; i++)
            expect_frame(8'(i * 17 + 3), i != 0, "R9 order");
        tail_idle("R9");

        // R7: enable dropped mid character
        cfg_enable = 1'b0;
        wr(8'h96);
        wr(8'h4B);
        @(negedge clk);
        cfg_enable = 1'b1;
        wait_start("R7");
        cfg_enable = 1'b0;
        check_body(8'h96, "R7 finishes character");
        begin
            bit held = 1;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (txd !== 1'b1 || tx_busy !== 1'b1 || tx_empty !== 1'b0) held = 0;
            end
            check(held, "R7 no start while disabled", held, 1);
        end
        cfg_enable = 1'b1;
        expect_frame(8'h4B, 0, "R7");
        tail_idle("R7");

        // R6: break during character with a queued byte
        cfg_enable = 1'b0;
        cfg_word_len = 2'b01;
        cfg_par_en = 1'b1;
        wr(8'h2D);
        wr(8'h11);
        @(negedge clk);
        cfg_enable = 1'b1;
        wait_start("R6");
        cfg_break = 1'b1;
        check_body(8'h2D, "R6 character completes before break");
        begin
            bit low = 1;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (txd !== 1'b0 || tx_busy !== 1'b1) low = 0;
            end
            check(low, "R6 line held low with byte queued", low, 1);
        end
        cfg_break = 1'b0;
        @(negedge clk);
        check(txd === 1'b1, "R6 line high after break clears", txd, 1);
        expect_frame(8'h11, 1, "R6 queued byte after break");
        tail_idle("R6");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule